// File: doc/BRIEF.md
# Latched Diagnostic Status Output

This block drives one active-high diagnostic pin for a serially commanded multi-channel output driver. The pin is low while all is well. It rises when any channel reports a short circuit or the die reports overtemperature. It also reports three remembered conditions: a command frame that ended with too few serial clocks, a frame that ran past the expected length, and an overtemperature episode that has already passed.

Each remembered condition is released at a different serial clock position of a later frame. The overtemperature memory is released only if the hot condition has gone. A host that watches the pin during its next command can therefore tell which fault was stored by the clock at which the pin drops. While the driver is in standby, the host can also request the pin high to test the diagnostic path.

The block does not detect serial edges and does not count clocks. It takes single-cycle event pulses for the chip-select and serial-clock edges, plus the running count of serial falling edges in the current frame. That count holds the number of falling edges already completed before the current system-clock cycle.

Top module: `diag_status_out`

## Requirements
- R1: After power-on reset, `statusOut` is 0 and no condition is remembered.
- R2: A high bit on any channel of `shortFlags` drives `statusOut` high. This fault is not remembered, so the pin falls again once the flags are clear.
- R3: A high `overTemp` drives `statusOut` high and is also remembered. The pin stays high after `overTemp` falls.
- R4: A chip-select rise inside a frame with `clkCount` below `FRAME_BITS` (8) stores a short-frame error. The error is shown on `statusOut`.
- R5: A stored short-frame error is released by the serial falling edge that arrives with `clkCount` equal to 7, which is the 8th clock of a frame. Earlier falling edges leave it in place.
- R6: A serial rising edge inside a frame with `clkCount` of at least 9 stores a long-frame error. This is the 9th clock, and the error is shown on `statusOut`.
- R7: A stored long-frame error is released by the serial falling edge that arrives with `clkCount` equal to 1, which is the 2nd clock of a frame.
- R8: The remembered overtemperature is released by the serial falling edge with `clkCount` equal to 3, which is the 4th clock. It is released only if `overTemp` is low in that cycle and is kept otherwise.
- R9: `selfTestReq` forces `statusOut` high only while `standby` is high. When `standby` is low, `selfTestReq` has no effect.
- R10: If a condition is stored and released in the same cycle, it stays stored.
- R11: Serial clock events outside a frame store nothing and release nothing. A frame is open from a chip-select fall until the next chip-select rise.
- R12: A frame that ends with exactly 8 clocks stores no error.
- R13: `statusOut` is registered. It reflects the inputs and events of a cycle after the next rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csFall | input | 1 | One-cycle pulse: chip select went low (frame opens) |
| csRise | input | 1 | One-cycle pulse: chip select went high (frame closes) |
| sclkFall | input | 1 | One-cycle pulse: serial clock falling edge |
| sclkRise | input | 1 | One-cycle pulse: serial clock rising edge |
| clkCount | input | CNT_W | Serial falling edges already completed in the current frame, saturating |
| shortFlags | input | CHANNELS | Live short-circuit flag per channel |
| overTemp | input | 1 | Live overtemperature flag |
| standby | input | 1 | Driver is in standby |
| selfTestReq | input | 1 | Request to force the pin high for a self test |
| statusOut | output | 1 | Active-high diagnostic output |

## Verification
The hardest case to reach from the ports is a stored short-frame error whose release and re-store land in the same system cycle. To create it, the bench opens a frame after a short frame, issues seven falling edges, and then drives the 8th falling edge with `clkCount` at 7 together with the chip-select rise. The pin must stay high. A second delicate case holds `overTemp` high through the 4th clock, which shows that the release is conditional. A third sends serial events outside a frame while an error is stored, which shows that they are ignored.

// File: rtl/diag_status_pkg.sv
package diag_status_pkg;
  // Strobes passed from the frame control to the status datapath
  typedef struct packed {
    logic setShort;
    logic setLong;
    logic clrShort;
    logic clrLong;
    logic clrOt;
  } diagStrobes_t;
endpackage

// File: rtl/diag_frame_ctrl.sv
module diag_frame_ctrl
  import diag_status_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csFall,
  input  logic             csRise,
  input  logic             sclkFall,
  input  logic             sclkRise,
  input  logic [CNT_W-1:0] clkCount,
  output logic             frameActive,
  output diagStrobes_t     strobes
);
  // Clock positions, as counts of falling edges completed before the event
  localparam logic [CNT_W-1:0] SHORT_CLR_POS = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] LONG_SET_CNT  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LONG_CLR_POS  = CNT_W'(1);
  localparam logic [CNT_W-1:0] OT_CLR_POS    = CNT_W'(3);
  localparam logic [CNT_W-1:0] FULL_CNT      = CNT_W'(FRAME_BITS);

  // Frame window: open after chip-select fall, closed by chip-select rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       frameActive <= 1'b0;
    else if (csRise) frameActive <= 1'b0;
    else if (csFall) frameActive <= 1'b1;
  end

  logic fallIn;
  logic riseIn;
  logic endIn;

  always_comb begin
    fallIn = frameActive & sclkFall;
    riseIn = frameActive & sclkRise;
    endIn  = frameActive & csRise;
    strobes.setShort = endIn  & (clkCount <  FULL_CNT);
    strobes.setLong  = riseIn & (clkCount >= LONG_SET_CNT);
    strobes.clrShort = fallIn & (clkCount == SHORT_CLR_POS);
    strobes.clrLong  = fallIn & (clkCount == LONG_CLR_POS);
    strobes.clrOt    = fallIn & (clkCount == OT_CLR_POS);
  end
endmodule

// File: rtl/diag_status_dp.sv
module diag_status_dp
  import diag_status_pkg::*;
#(
  parameter int CHANNELS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  diagStrobes_t        strobes,
  input  logic [CHANNELS-1:0] shortFlags,
  input  logic                overTemp,
  input  logic                standby,
  input  logic                selfTestReq,
  output logic                shortErr,
  output logic                longErr,
  output logic                otLatch,
  output logic                statusOut
);
  logic shortNext;
  logic longNext;
  logic otNext;
  logic liveFault;
  logic testForce;
  logic statusNext;

  // Set has priority over release; overtemperature sets itself while present
  always_comb begin
    shortNext  = strobes.setShort | (shortErr & ~strobes.clrShort);
    longNext   = strobes.setLong  | (longErr  & ~strobes.clrLong);
    otNext     = overTemp         | (otLatch  & ~strobes.clrOt);
    liveFault  = (|shortFlags) | overTemp;
    testForce  = standby & selfTestReq;
    statusNext = liveFault | testForce | shortNext | longNext | otNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shortErr  <= 1'b0;
      longErr   <= 1'b0;
      otLatch   <= 1'b0;
      statusOut <= 1'b0;
    end else begin
      shortErr  <= shortNext;
      longErr   <= longNext;
      otLatch   <= otNext;
      statusOut <= statusNext;
    end
  end
endmodule

// File: rtl/diag_status_out.sv
module diag_status_out
  import diag_status_pkg::*;
#(
  parameter int CHANNELS   = 8,
  parameter int FRAME_BITS = 8,
  parameter int CNT_W      = $clog2(FRAME_BITS + 3)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csFall,
  input  logic                csRise,
  input  logic                sclkFall,
  input  logic                sclkRise,
  input  logic [CNT_W-1:0]    clkCount,
  input  logic [CHANNELS-1:0] shortFlags,
  input  logic                overTemp,
  input  logic                standby,
  input  logic                selfTestReq,
  output logic                statusOut
);
  diagStrobes_t strobes;
  logic frameActive;
  logic shortErr;
  logic longErr;
  logic otLatch;

  diag_frame_ctrl #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csFall(csFall), .csRise(csRise),
    .sclkFall(sclkFall), .sclkRise(sclkRise), .clkCount(clkCount),
    .frameActive(frameActive), .strobes(strobes)
  );

  diag_status_dp #(.CHANNELS(CHANNELS)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .shortFlags(shortFlags),
    .overTemp(overTemp), .standby(standby), .selfTestReq(selfTestReq),
    .shortErr(shortErr), .longErr(longErr), .otLatch(otLatch),
    .statusOut(statusOut)
  );
endmodule

// File: rtl/diag_status_chk.sv
module diag_status_chk #(
  parameter int CHANNELS   = 8,
  parameter int FRAME_BITS = 8,
  parameter int CNT_W      = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                csRise,
  input logic                sclkRise,
  input logic [CNT_W-1:0]    clkCount,
  input logic [CHANNELS-1:0] shortFlags,
  input logic                overTemp,
  input logic                standby,
  input logic                selfTestReq,
  input logic                frameActive,
  input logic                shortErr,
  input logic                longErr,
  input logic                otLatch,
  input logic                statusOut
);
  assert_live_short_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|shortFlags) |=> statusOut);

  assert_ot_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
    overTemp |=> (statusOut && otLatch));

  assert_short_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    (frameActive && csRise && (clkCount < CNT_W'(FRAME_BITS))) |=> (shortErr && statusOut));

  assert_long_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameActive && sclkRise && (clkCount >= CNT_W'(FRAME_BITS + 1))) |=> (longErr && statusOut));

  assert_ot_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (otLatch && overTemp) |=> otLatch);

  assert_self_test_R9: assert property (@(posedge clk) disable iff (!rstN)
    (standby && selfTestReq) |=> statusOut);

  assert_idle_serial_R11: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |=> ($stable(shortErr) && $stable(longErr)));
endmodule

bind diag_status_out diag_status_chk #(
  .CHANNELS(CHANNELS), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)
) uChk (
  .clk(clk), .rstN(rstN), .csRise(csRise), .sclkRise(sclkRise),
  .clkCount(clkCount), .shortFlags(shortFlags), .overTemp(overTemp),
  .standby(standby), .selfTestReq(selfTestReq), .frameActive(frameActive),
  .shortErr(shortErr), .longErr(longErr), .otLatch(otLatch),
  .statusOut(statusOut)
);

// File: tb/sim_diag_status_out.sv
module sim_diag_status_out;
  localparam int CH = 8;
  localparam int FB = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csFall = 0, csRise = 0, sclkFall = 0, sclkRise = 0;
  logic [CW-1:0] clkCount = '0;
  logic [CH-1:0] shortFlags = '0;
  logic overTemp = 0, standby = 0, selfTestReq = 0;
  logic statusOut;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  diag_status_out #(.CHANNELS(CH), .FRAME_BITS(FB), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .csFall(csFall), .csRise(csRise),
    .sclkFall(sclkFall), .sclkRise(sclkRise), .clkCount(clkCount),
    .shortFlags(shortFlags), .overTemp(overTemp), .standby(standby),
    .selfTestReq(selfTestReq), .statusOut(statusOut)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s statusOut=%b expected=%b", req, act, exp);
    end
  endtask

  // One system cycle: inputs set before the call are taken at the edge
  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  // Frame of nClk serial clocks; status checked after each of the first FB falls
  task automatic runFrame(int nClk, bit startHigh, int dropAt, string req);
    csFall = 1; cyc(); csFall = 0;
    for (int i = 0; i < nClk; i++) begin
      clkCount = CW'(i); sclkFall = 1; cyc(); sclkFall = 0;
      if (i < FB) chk(req, statusOut, startHigh && !(dropAt >= 0 && i >= dropAt));
      clkCount = CW'(i + 1); sclkRise = 1; cyc(); sclkRise = 0;
      if (i + 1 == FB + 1) chk("R6 long frame stored at 9th rise", statusOut, 1'b1);
    end
    clkCount = CW'(nClk); csRise = 1; cyc(); csRise = 0; clkCount = '0;
  endtask

  task automatic testReset();
    chk("R1 reset state", statusOut, 1'b0);
  endtask

  task automatic testGoodFrame();
    runFrame(FB, 0, -1, "R12 good frame clocks");
    chk("R12 exact frame stores nothing", statusOut, 1'b0);
  endtask

  task automatic testShortFrame();
    runFrame(5, 0, -1, "R4 short frame clocks");
    chk("R4 short frame stored", statusOut, 1'b1);
    runFrame(FB, 1, FB - 1, "R5 short error release at 8th fall");
    chk("R5 released after frame", statusOut, 1'b0);
  endtask

  task automatic testLongFrame();
    runFrame(10, 0, -1, "R6 long frame clocks");
    chk("R6 long error held after frame", statusOut, 1'b1);
    runFrame(FB, 1, 1, "R7 long error release at 2nd fall");
    chk("R7 released after frame", statusOut, 1'b0);
  endtask

  task automatic testOverTemp();
    overTemp = 1; cyc();
    chk("R3 live overtemperature", statusOut, 1'b1);
    overTemp = 0; cyc();
    chk("R3 overtemperature remembered", statusOut, 1'b1);
    overTemp = 1;
    runFrame(FB, 1, -1, "R8 kept while still hot");
    chk("R8 kept while still hot after frame", statusOut, 1'b1);
    overTemp = 0;
    runFrame(FB, 1, 3, "R8 release at 4th fall");
    chk("R8 released after frame", statusOut, 1'b0);
  endtask

  task automatic testShortFlags();
    for (int c = 0; c < CH; c++) begin
      shortFlags = CH'(1) << c;
      #1;
      chk("R13 no change before clock edge", statusOut, 1'b0);
      cyc();
      chk("R2 channel short drives high", statusOut, 1'b1);
      shortFlags = '0; cyc();
      chk("R2 short not remembered", statusOut, 1'b0);
    end
  endtask

  task automatic testSelfTest();
    standby = 0; selfTestReq = 1; cyc();
    chk("R9 self test ignored outside standby", statusOut, 1'b0);
    standby = 1; cyc();
    chk("R9 self test in standby", statusOut, 1'b1);
    selfTestReq = 0; cyc();
    chk("R9 standby alone stays low", statusOut, 1'b0);
    standby = 0; cyc();
  endtask

  task automatic testIdleSerial();
    clkCount = CW'(9); sclkRise = 1; cyc(); sclkRise = 0; cyc();
    chk("R11 rise outside frame stores nothing", statusOut, 1'b0);
    runFrame(3, 0, -1, "R11 setup short frame");
    clkCount = CW'(FB - 1); sclkFall = 1; cyc(); sclkFall = 0; cyc();
    chk("R11 fall outside frame releases nothing", statusOut, 1'b1);
    clkCount = '0;
    runFrame(FB, 1, FB - 1, "R11 cleanup release");
  endtask

  task automatic testSetWins();
    runFrame(4, 0, -1, "R10 setup short frame");
    chk("R10 setup stored", statusOut, 1'b1);
    csFall = 1; cyc(); csFall = 0;
    for (int i = 0; i < FB - 1; i++) begin
      clkCount = CW'(i); sclkFall = 1; cyc(); sclkFall = 0;
      clkCount = CW'(i + 1); sclkRise = 1; cyc(); sclkRise = 0;
    end
    clkCount = CW'(FB - 1); sclkFall = 1; csRise = 1; cyc();
    sclkFall = 0; csRise = 0; clkCount = '0;
    chk("R10 store wins over release", statusOut, 1'b1);
    runFrame(FB, 1, FB - 1, "R10 cleanup release");
  endtask

  initial begin
    #4_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #5;
    cyc(); cyc();
    testReset();
    rstN = 1; cyc();
    testReset();
    testGoodFrame();
    testShortFrame();
    testLongFrame();
    testOverTemp();
    testShortFlags();
    testSelfTest();
    testIdleSerial();
    testSetWins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule